// File: doc/BRIEF.md
# Bridge Primary Status Register

This block holds the 16-bit primary status word of a bridge function's configuration header. Event strobes from the bridge's link and bus logic set individual flag bits. Each flag stays set until software writes a 1 to its position. A write port with two byte enables carries the clears. The read value is always visible on a combinational read bus.

Two of the flags depend on a parity-error-response enable from the companion command register. A third flag records parity errors on the upstream link whatever that enable is. When a downstream-bus parity error first sets the system-error flag while the system-error enable is on, the block emits a one-cycle non-maskable interrupt request.

An event strobe is sampled at a rising clock edge, and its flag reads 1 from that edge onward.

Top module: `bridge_pri_status`

## Requirements
- R1: After reset, `rd_data` reads 0x0080.
- R2: Bit 7 always reads 1. Bits 10:9, 6:5 and 4:0 always read 0. Writes to these bits have no effect.
- R3: A write with `wr_en` high clears each writable flag (bits 15, 14, 13, 12, 11, 8) whose data bit is 1 and whose byte lane is enabled. A data bit of 0 leaves its flag unchanged.
- R4: `wr_be[1]` enables the clears for bits 15:8. A write with only `wr_be[0]` set changes no flag.
- R5: Bit 15 sets on `ev_link_perr` whether `perr_resp_en` is 0 or 1.
- R6: Bit 8 sets on `ev_link_perr` only when `perr_resp_en` is 1.
- R7: Bit 14 sets on `ev_bus_perr` only when `perr_resp_en` is 1.
- R8: Bits 13, 12 and 11 set on `ev_rx_mabort`, `ev_rx_tabort` and `ev_sig_tabort` respectively.
- R9: If a set event and a write-1 clear hit the same flag in the same cycle, the flag ends at 1.
- R10: `nmi_req` is high for exactly one cycle, in the first cycle in which bit 14 reads 1, and only when `serr_en` was 1 at the setting event and bit 14 was 0 before that event. A set event while bit 14 is already 1 produces no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_be | input | 2 | Byte enables: bit 0 for data 7:0, bit 1 for data 15:8 |
| wr_data | input | 16 | Write data; 1 clears a flag |
| rd_data | output | 16 | Current register value |
| perr_resp_en | input | 1 | Parity-error-response enable from the command register |
| serr_en | input | 1 | System-error enable from the command register |
| ev_link_perr | input | 1 | Parity error detected on the upstream link |
| ev_bus_perr | input | 1 | Address, command or special-cycle data parity error on the downstream bus |
| ev_rx_mabort | input | 1 | Master abort received |
| ev_rx_tabort | input | 1 | Target abort received |
| ev_sig_tabort | input | 1 | Target abort signaled by this device |
| nmi_req | output | 1 | One-cycle non-maskable interrupt request |

## Verification
All results are due one clock edge after the stimulus. A flag set or cleared at an edge shows on `rd_data` right after that edge, and `nmi_req` rises at the same edge and falls at the next one. The bench drives each stimulus on the falling edge and holds it through one rising edge. It removes the stimulus shortly after that edge and then samples. A second sample one cycle later confirms that the interrupt pulse has ended. Sticky flags are checked again after that cycle has passed with no stimulus.

// File: rtl/bridge_pri_status.sv
module bridge_pri_status #(
  parameter logic [15:0] RESET_VAL = 16'h0080
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_be,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data,
  input  logic        perr_resp_en,
  input  logic        serr_en,
  input  logic        ev_link_perr,
  input  logic        ev_bus_perr,
  input  logic        ev_rx_mabort,
  input  logic        ev_rx_tabort,
  input  logic        ev_sig_tabort,
  output logic        nmi_req
);

  localparam logic [15:0] W1C_MASK = 16'hF900;
  localparam logic [15:0] RO_VAL   = RESET_VAL & ~W1C_MASK;

  logic [15:0] flags_q;
  logic [15:0] set_vec;
  logic [15:0] clr_vec;
  logic        bus_perr_set;

  assign bus_perr_set = ev_bus_perr & perr_resp_en;

  always_comb begin
    set_vec     = '0;
    set_vec[15] = ev_link_perr;
    set_vec[14] = bus_perr_set;
    set_vec[13] = ev_rx_mabort;
    set_vec[12] = ev_rx_tabort;
    set_vec[11] = ev_sig_tabort;
    set_vec[8]  = ev_link_perr & perr_resp_en;
  end

  assign clr_vec = {16{wr_en}} & {{8{wr_be[1]}}, {8{wr_be[0]}}} & wr_data & W1C_MASK;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
      nmi_req <= 1'b0;
    end else begin
      flags_q <= ((flags_q & ~clr_vec) | set_vec) & W1C_MASK;
      nmi_req <= bus_perr_set & serr_en & ~flags_q[14];
    end
  end

  assign rd_data = flags_q | RO_VAL;

  // R2
  ro_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~W1C_MASK) == 16'h0080);

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_mabort |=> rd_data[13]);

  // R3
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_be[1] && wr_data[12] && !ev_rx_tabort) |=> !rd_data[12]);

  // R6
  dpd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[8]) |-> $past(ev_link_perr && perr_resp_en));

  // R10
  nmi_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |=> !nmi_req);

  // R10
  nmi_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |-> (rd_data[14] && $past(serr_en) && !$past(rd_data[14])));

endmodule

// File: tb/test_bridge_pri_status.sv
module test_bridge_pri_status;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_be;
  logic [15:0] wr_data;
  logic [15:0] rd_data;
  logic        perr_resp_en;
  logic        serr_en;
  logic        ev_link_perr, ev_bus_perr, ev_rx_mabort, ev_rx_tabort, ev_sig_tabort;
  logic        nmi_req;

  int n_checks = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  bridge_pri_status i_bridge_pri_status (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
    .rd_data(rd_data), .perr_resp_en(perr_resp_en), .serr_en(serr_en),
    .ev_link_perr(ev_link_perr), .ev_bus_perr(ev_bus_perr),
    .ev_rx_mabort(ev_rx_mabort), .ev_rx_tabort(ev_rx_tabort),
    .ev_sig_tabort(ev_sig_tabort), .nmi_req(nmi_req)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // ev = {sig_tabort, rx_tabort, rx_mabort, bus_perr, link_perr}
  task automatic cycle(input logic [4:0] ev, input logic we, input logic [1:0] be,
                       input logic [15:0] d);
    @(negedge clk);
    {ev_sig_tabort, ev_rx_tabort, ev_rx_mabort, ev_bus_perr, ev_link_perr} = ev;
    wr_en = we; wr_be = be; wr_data = d;
    @(posedge clk);
    #2;
    {ev_sig_tabort, ev_rx_tabort, ev_rx_mabort, ev_bus_perr, ev_link_perr} = '0;
    wr_en = 1'b0; wr_be = '0; wr_data = '0;
  endtask

  task automatic clear_all();
    cycle(5'b0, 1'b1, 2'b11, 16'hFFFF);
  endtask

  task automatic t_reset();
    check("R1 reset value", rd_data, 16'h0080);
    check("R1 nmi idle", {15'b0, nmi_req}, 16'h0);
  endtask

  task automatic t_link_perr();
    perr_resp_en = 1'b0;
    cycle(5'b00001, 1'b0, 2'b00, 16'h0);
    check("R5 bit15 ungated / R6 bit8 gated off", rd_data, 16'h8080);
    clear_all();
    perr_resp_en = 1'b1;
    cycle(5'b00001, 1'b0, 2'b00, 16'h0);
    check("R6 bit8 and R5 bit15 with enable", rd_data, 16'h8180);
    clear_all();
  endtask

  task automatic t_bus_perr();
    perr_resp_en = 1'b0; serr_en = 1'b1;
    cycle(5'b00010, 1'b0, 2'b00, 16'h0);
    check("R7 bit14 gated off", rd_data, 16'h0080);
    check("R10 no nmi when gated", {15'b0, nmi_req}, 16'h0);
    perr_resp_en = 1'b1; serr_en = 1'b0;
    cycle(5'b00010, 1'b0, 2'b00, 16'h0);
    check("R7 bit14 set", rd_data, 16'h4080);
    check("R10 no nmi without serr_en", {15'b0, nmi_req}, 16'h0);
    clear_all();
  endtask

  task automatic t_nmi();
    perr_resp_en = 1'b1; serr_en = 1'b1;
    cycle(5'b00010, 1'b0, 2'b00, 16'h0);
    check("R10 nmi pulse high", {15'b0, nmi_req}, 16'h1);
    @(posedge clk); #2;
    check("R10 nmi pulse ends", {15'b0, nmi_req}, 16'h0);
    check("R7 bit14 sticky", rd_data, 16'h4080);
    cycle(5'b00010, 1'b0, 2'b00, 16'h0);
    check("R10 no nmi when already set", {15'b0, nmi_req}, 16'h0);
    clear_all();
    cycle(5'b00010, 1'b0, 2'b00, 16'h0);
    check("R10 nmi again after clear", {15'b0, nmi_req}, 16'h1);
    clear_all();
    serr_en = 1'b0;
  endtask

  task automatic t_aborts();
    cycle(5'b00100, 1'b0, 2'b00, 16'h0);
    check("R8 rx master abort bit13", rd_data, 16'h2080);
    clear_all();
    cycle(5'b01000, 1'b0, 2'b00, 16'h0);
    check("R8 rx target abort bit12", rd_data, 16'h1080);
    clear_all();
    cycle(5'b10000, 1'b0, 2'b00, 16'h0);
    check("R8 signaled target abort bit11", rd_data, 16'h0880);
    clear_all();
  endtask

  task automatic t_w1c();
    perr_resp_en = 1'b1;
    cycle(5'b11111, 1'b0, 2'b00, 16'h0);
    check("R3 all flags set", rd_data, 16'hF980);
    cycle(5'b0, 1'b1, 2'b10, 16'h2000);
    check("R3 single clear bit13", rd_data, 16'hD980);
    cycle(5'b0, 1'b1, 2'b11, 16'h0000);
    check("R3 write zero no effect", rd_data, 16'hD980);
    cycle(5'b0, 1'b1, 2'b01, 16'hFFFF);
    check("R4 low lane only no effect", rd_data, 16'hD980);
    cycle(5'b0, 1'b1, 2'b00, 16'hFFFF);
    check("R4 no lanes no effect", rd_data, 16'hD980);
    cycle(5'b0, 1'b0, 2'b10, 16'hFFFF);
    check("R3 no wr_en no effect", rd_data, 16'hD980);
    cycle(5'b0, 1'b1, 2'b10, 16'hFFFF);
    check("R4 high lane clears all", rd_data, 16'h0080);
  endtask

  task automatic t_ro();
    cycle(5'b0, 1'b1, 2'b11, 16'h0000);
    check("R2 write zero to ro bits", rd_data, 16'h0080);
    cycle(5'b0, 1'b1, 2'b11, 16'hFFFF);
    check("R2 write ones to ro bits", rd_data, 16'h0080);
  endtask

  task automatic t_collision();
    cycle(5'b00100, 1'b0, 2'b00, 16'h0);
    cycle(5'b00100, 1'b1, 2'b10, 16'h2000);
    check("R9 set beats clear", rd_data, 16'h2080);
    @(posedge clk); #2;
    check("R9 flag held", rd_data, 16'h2080);
    clear_all();
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_be = '0; wr_data = '0;
    perr_resp_en = 1'b0; serr_en = 1'b0;
    {ev_sig_tabort, ev_rx_tabort, ev_rx_mabort, ev_bus_perr, ev_link_perr} = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    t_reset();
    t_link_perr();
    t_bus_perr();
    t_nmi();
    t_aborts();
    t_w1c();
    t_ro();
    t_collision();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule